// File: doc/BRIEF.md
# Pipelined Reduced-Precision Floating-Point Multiplier

This block multiplies two numbers held in a compact 19-bit floating-point word. The word has one sign bit, an 8-bit exponent with a bias of 127 and a 10-bit stored fraction. The exponent field is as wide as in single precision, so the range is the same, and the fraction is the size of a half-precision fraction. The block suits arithmetic arrays that need wide dynamic range but can accept a short significand. Values with a zero exponent field are always treated as zero, both at the inputs and at the output.

The datapath has three register stages. The first stage decodes both operands, multiplies the 11-bit significands and sums the biased exponents. The second stage normalizes the 22-bit product and extracts the guard and sticky bits. The third stage rounds to nearest with ties to even, resolves the special cases and packs the result word and a set of exception flags.

A valid strobe travels alongside the data. One new operand pair may be presented on every cycle, and there is no back-pressure. Every result emerges a fixed three cycles after its operands, in order.

Top module: `fpm_mul`

## Requirements
- R1: For two normal operands the result word is {sign[18], biased exponent[17:10], fraction[9:0]}. Its exponent is ea + eb − 127, increased by one when the significand product is 2.0 or more, and its fraction is the rounded normalized product.
- R2: out_valid is high in cycle n+3 exactly when in_valid was high in cycle n. Results leave in issue order, and out_valid never rises without a matching input.
- R3: While rst_n is low, out_valid is 0, and it drops at once when rst_n falls. Operand pairs still in flight at that moment produce no output.
- R4: An input with exponent field 0 is a zero of its own sign, whatever its fraction bits hold.
- R5: Rounding is to nearest. An exact half rounds to the neighbour with an even fraction LSB. A round-up that carries out of the fraction gives fraction 0 and increments the exponent.
- R6: If the exponent after rounding exceeds 254, the result is infinity (exponent 255, fraction 0) and out_overflow is 1. This includes the case where the rounding carry pushes the exponent from 254 to 255.
- R7: If the exponent after rounding is below 1, the result is a signed zero (exponent 0, fraction 0) and out_underflow is 1. A product whose rounding carry lifts it to exponent 1 is returned as that normal number with no flag.
- R8: Zero times infinity (in either order) returns the quiet NaN 19'h3FE00 (sign 0, exponent 255, fraction MSB set) with out_invalid = 1.
- R9: Any NaN operand (exponent 255, nonzero fraction) returns 19'h3FE00 with no flag raised. This rule takes priority over R8.
- R10: Infinity times a nonzero number or infinity returns infinity, and zero times a finite number returns zero, with no flag raised in either case. At most one flag is ever set.
- R11: Every non-NaN result carries the XOR of the two operand signs.
- R12: Operand pairs may be presented on consecutive cycles with no gap, and each produces its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 19 | First operand |
| in_b | input | 19 | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 19 | Product word |
| out_overflow | output | 1 | Result overflowed to infinity |
| out_underflow | output | 1 | Result underflowed to zero |
| out_invalid | output | 1 | Zero times infinity |

## Verification
Each kind of internal fault shows up at the ports in the result it affects, three cycles after the operands that expose it. A slip in normalization or in the round-up decision appears as a fraction off by one LSB or an exponent off by one. A wrong special-case decode appears as a missing or extra flag next to a malformed infinity, zero or NaN word. A broken valid pipeline moves out_valid away from cycle n+3 or drops a result, and the very next issued pair shows it. Random operands are weighted toward extreme exponents, all-ones fractions and special encodings, so that every rounding carry and every boundary where a flag changes is reached early, in addition to the directed cases.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Operand classification after decode
  typedef struct packed {
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } opclass_t;

  // Result class chosen in the first stage
  typedef enum logic [2:0] {
    SP_NORM,
    SP_ZERO,
    SP_INF,
    SP_NAN,
    SP_INVALID
  } special_e;

  typedef struct packed {
    logic invalid;
    logic underflow;
    logic overflow;
  } flags_t;

  // NaN wins over zero*inf, which wins over infinity, which wins over zero
  function automatic special_e resolve_special(input opclass_t a, input opclass_t b);
    special_e r;
    if (a.is_nan || b.is_nan)
      r = SP_NAN;
    else if ((a.is_zero && b.is_inf) || (a.is_inf && b.is_zero))
      r = SP_INVALID;
    else if (a.is_inf || b.is_inf)
      r = SP_INF;
    else if (a.is_zero || b.is_zero)
      r = SP_ZERO;
    else
      r = SP_NORM;
    return r;
  endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  sign,
  output logic [FRAC_W:0]       signif,
  output logic [EXP_W-1:0]      bexp,
  output opclass_t              cls
);

  localparam int W = EXP_W + FRAC_W + 1;

  logic [FRAC_W-1:0] frac;
  logic              exp_zero;
  logic              exp_ones;

  always_comb begin
    sign     = op[W-1];
    bexp     = op[W-2 -: EXP_W];
    frac     = op[FRAC_W-1:0];
    exp_zero = (bexp == '0);
    exp_ones = (bexp == '1);
    // exponent zero means zero: subnormal fractions are dropped
    cls.is_zero = exp_zero;
    cls.is_inf  = exp_ones && (frac == '0);
    cls.is_nan  = exp_ones && (frac != '0);
    signif      = {~exp_zero, frac};
  end

endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic [2*FRAC_W+1:0]       prod,
  input  logic signed [EXP_W+1:0]   esum,
  output logic [FRAC_W-1:0]         mant,
  output logic                      guard,
  output logic                      sticky,
  output logic signed [EXP_W+1:0]   exp_n
);

  localparam int PW = 2 * (FRAC_W + 1);
  localparam int EW = EXP_W + 2;

  logic          top;
  logic [PW-1:0] aligned;

  always_comb begin
    top     = prod[PW-1];
    // leading one placed at PW-1 in both cases
    aligned = top ? prod : {prod[PW-2:0], 1'b0};
    mant    = aligned[PW-2 -: FRAC_W];
    guard   = aligned[PW-2-FRAC_W];
    sticky  = |aligned[PW-3-FRAC_W:0];
    exp_n   = esum + $signed({{(EW-1){1'b0}}, top});
  end

endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic                    sign,
  input  special_e                sp,
  input  logic [FRAC_W-1:0]       mant,
  input  logic                    guard,
  input  logic                    sticky,
  input  logic signed [EXP_W+1:0] exp_n,
  output logic [EXP_W+FRAC_W:0]   result,
  output flags_t                  flags
);

  localparam int W  = EXP_W + FRAC_W + 1;
  localparam int EW = EXP_W + 2;
  localparam logic signed [EW-1:0] EXP_MAX = EW'((1 << EXP_W) - 2);
  localparam logic signed [EW-1:0] EXP_MIN = EW'(1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic                 up;
  logic                 carry;
  logic [FRAC_W-1:0]    frac_r;
  logic signed [EW-1:0] exp_r;
  logic                 ovf;
  logic                 unf;

  always_comb begin
    up             = guard & (sticky | mant[0]);
    {carry, frac_r} = {1'b0, mant} + {{FRAC_W{1'b0}}, up};
    exp_r          = exp_n + $signed({{(EW-1){1'b0}}, carry});
    ovf            = (exp_r > EXP_MAX);
    unf            = (exp_r < EXP_MIN);

    flags  = '0;
    result = '0;
    unique case (sp)
      SP_NORM: begin
        if (ovf) begin
          result         = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          flags.overflow = 1'b1;
        end else if (unf) begin
          result          = {sign, {(W-1){1'b0}}};
          flags.underflow = 1'b1;
        end else begin
          result = {sign, exp_r[EXP_W-1:0], frac_r};
        end
      end
      SP_ZERO:    result = {sign, {(W-1){1'b0}}};
      SP_INF:     result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      SP_NAN:     result = QNAN;
      SP_INVALID: begin
        result        = QNAN;
        flags.invalid = 1'b1;
      end
      default:    result = QNAN;
    endcase
  end

endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_a,
  input  logic [EXP_W+FRAC_W:0] in_b,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_result,
  output logic                  out_overflow,
  output logic                  out_underflow,
  output logic                  out_invalid
);

  localparam int W       = EXP_W + FRAC_W + 1;
  localparam int SW      = FRAC_W + 1;
  localparam int PW      = 2 * SW;
  localparam int EW      = EXP_W + 2;
  localparam int LATENCY = 3;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);

  // ---------------- stage 0: decode and multiply ----------------
  logic [W-1:0]      opnd   [2];
  logic              sgn    [2];
  logic [SW-1:0]     sig    [2];
  logic [EXP_W-1:0]  bexp   [2];
  opclass_t          cls    [2];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .op     (opnd[g]),
      .sign   (sgn[g]),
      .signif (sig[g]),
      .bexp   (bexp[g]),
      .cls    (cls[g])
    );
  end

  logic                 s1_sign_d;
  special_e             s1_sp_d;
  logic [PW-1:0]        s1_prod_d;
  logic signed [EW-1:0] s1_esum_d;

  always_comb begin
    s1_sign_d = sgn[0] ^ sgn[1];
    s1_sp_d   = resolve_special(cls[0], cls[1]);
    s1_prod_d = {{SW{1'b0}}, sig[0]} * {{SW{1'b0}}, sig[1]};
    s1_esum_d = $signed({2'b00, bexp[0]}) + $signed({2'b00, bexp[1]}) - BIAS_S;
  end

  logic                 s1_sign_q;
  special_e             s1_sp_q;
  logic [PW-1:0]        s1_prod_q;
  logic signed [EW-1:0] s1_esum_q;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sign_q <= s1_sign_d;
      s1_sp_q   <= s1_sp_d;
      s1_prod_q <= s1_prod_d;
      s1_esum_q <= s1_esum_d;
    end
  end

  // ---------------- stage 1: normalize ----------------
  logic [FRAC_W-1:0]    s2_mant_d;
  logic                 s2_guard_d;
  logic                 s2_sticky_d;
  logic signed [EW-1:0] s2_exp_d;

  fpm_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .prod   (s1_prod_q),
    .esum   (s1_esum_q),
    .mant   (s2_mant_d),
    .guard  (s2_guard_d),
    .sticky (s2_sticky_d),
    .exp_n  (s2_exp_d)
  );

  logic                 s2_sign_q;
  special_e             s2_sp_q;
  logic [FRAC_W-1:0]    s2_mant_q;
  logic                 s2_guard_q;
  logic                 s2_sticky_q;
  logic signed [EW-1:0] s2_exp_q;

  logic [LATENCY-1:0] vld_d;
  logic [LATENCY-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      s2_sign_q   <= s1_sign_q;
      s2_sp_q     <= s1_sp_q;
      s2_mant_q   <= s2_mant_d;
      s2_guard_q  <= s2_guard_d;
      s2_sticky_q <= s2_sticky_d;
      s2_exp_q    <= s2_exp_d;
    end
  end

  // ---------------- stage 2: round and pack ----------------
  logic [W-1:0] s3_res_d;
  flags_t       s3_flags_d;

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sign   (s2_sign_q),
    .sp     (s2_sp_q),
    .mant   (s2_mant_q),
    .guard  (s2_guard_q),
    .sticky (s2_sticky_q),
    .exp_n  (s2_exp_q),
    .result (s3_res_d),
    .flags  (s3_flags_d)
  );

  logic [W-1:0] s3_res_q;
  flags_t       s3_flags_q;

  always_ff @(posedge clk) begin
    if (vld_q[1]) begin
      s3_res_q   <= s3_res_d;
      s3_flags_q <= s3_flags_d;
    end
  end

  // ---------------- valid pipeline ----------------
  always_comb begin
    vld_d = {vld_q[LATENCY-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign out_valid     = vld_q[LATENCY-1];
  assign out_result    = s3_res_q;
  assign out_overflow  = s3_flags_q.overflow;
  assign out_underflow = s3_flags_q.underflow;
  assign out_invalid   = s3_flags_q.invalid;

  // ---------------- assertions ----------------
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  localparam logic [W-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // R2: output strobe follows the input strobe by exactly three cycles
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R3: reset empties the valid pipeline
  always @(negedge clk) begin
    if (!rst_n) p_reset_clear_r3: assert (out_valid == 1'b0);
  end

  // R6: overflow flag comes with a properly formed infinity
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |->
      (out_result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  // R7: underflow flag comes with a zero word
  p_underflow_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_result[W-2:0] == '0));

  // R8: invalid flag comes with the canonical quiet NaN
  p_invalid_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result == QNAN_W));

  // R10: flags are mutually exclusive
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_overflow, out_underflow, out_invalid}));

  // R11: non-NaN results carry the XOR of the operand signs
  p_sign_xor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 2'd3) && out_valid &&
     !((out_result[W-2 -: EXP_W] == '1) && (out_result[FRAC_W-1:0] != '0)))
      |-> (out_result[W-1] == $past(in_a[W-1] ^ in_b[W-1], 3)));

endmodule

// File: tb/fpm_mul_bench.sv
`timescale 1ns/1ps
module fpm_mul_bench;

  localparam int DEPTH = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [18:0] in_a, in_b;
  logic        out_valid;
  logic [18:0] out_result;
  logic        out_overflow, out_underflow, out_invalid;

  always #2.5 clk = ~clk;

  fpm_mul u_fpm_mul (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_a          (in_a),
    .in_b          (in_b),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_overflow  (out_overflow),
    .out_underflow (out_underflow),
    .out_invalid   (out_invalid)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int iss    = 0;
  int rcv    = 0;
  bit done   = 1'b0;

  logic [21:0] exp_mem  [DEPTH];
  int          issue_cyc[DEPTH];
  string       tag_mem  [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [18:0] mk(input logic s, input int e, input int f);
    return {s, 8'(e), 10'(f)};
  endfunction

  // reference: {invalid, underflow, overflow, result}
  function automatic logic [21:0] ref_mul(input logic [18:0] a, input logic [18:0] b);
    int ea, eb, fa, fb, e, m, sh, rem, half, p;
    logic s;
    bit nan_a, nan_b, inf_a, inf_b, z_a, z_b;
    ea = int'(a[17:10]); eb = int'(b[17:10]);
    fa = int'(a[9:0]);   fb = int'(b[9:0]);
    nan_a = (ea == 255) && (fa != 0); nan_b = (eb == 255) && (fb != 0);
    inf_a = (ea == 255) && (fa == 0); inf_b = (eb == 255) && (fb == 0);
    z_a = (ea == 0); z_b = (eb == 0);
    s = a[18] ^ b[18];
    if (nan_a || nan_b) return {3'b000, 19'h3FE00};
    if ((inf_a && z_b) || (z_a && inf_b)) return {3'b100, 19'h3FE00};
    if (inf_a || inf_b) return {3'b000, s, 8'hFF, 10'h000};
    if (z_a || z_b) return {3'b000, s, 18'h0};
    p  = (1024 + fa) * (1024 + fb);
    e  = ea + eb - 127;
    sh = 10;
    if (p >= (1 << 21)) begin sh = 11; e = e + 1; end
    m    = p >> sh;
    rem  = p - (m << sh);
    half = 1 << (sh - 1);
    if ((rem > half) || ((rem == half) && (m % 2 == 1))) m = m + 1;
    if (m == 2048) begin m = 1024; e = e + 1; end
    if (e > 254) return {3'b001, s, 8'hFF, 10'h000};
    if (e < 1)   return {3'b010, s, 18'h0};
    return {3'b000, s, 8'(e), 10'(m - 1024)};
  endfunction

  function automatic logic [18:0] rand_op();
    int k, e, f;
    logic s;
    k = int'($urandom_range(0, 15));
    s = 1'($urandom);
    f = int'($urandom_range(0, 1023));
    case (k)
      0:       e = 0;
      1:       begin e = 255; f = 0; end
      2:       begin e = 255; f = f | 1; end
      3:       e = int'($urandom_range(1, 8));
      4:       e = int'($urandom_range(246, 254));
      5:       begin e = int'($urandom_range(60, 70)); f = 1023 - (f % 4); end
      6:       begin e = int'($urandom_range(186, 195)); f = int'($urandom_range(400, 1023)); end
      default: e = int'($urandom_range(70, 185));
    endcase
    return mk(s, e, f);
  endfunction

  task automatic send(input logic [18:0] a, input logic [18:0] b, input string tag);
    @(negedge clk);
    in_valid       = 1'b1;
    in_a           = a;
    in_b           = b;
    exp_mem[iss]   = ref_mul(a, b);
    issue_cyc[iss] = cyc;
    tag_mem[iss]   = tag;
    iss++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a     = 19'h0;
      in_b     = 19'h0;
    end
  endtask

  // output checker, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && !done) begin
      checks++;
      if (rcv >= iss) begin
        errors++;
        $display("FAIL R2: out_valid with no pending input (actual 1, expected 0)");
      end else begin
        if ({out_invalid, out_underflow, out_overflow, out_result} !== exp_mem[rcv]) begin
          errors++;
          $display("FAIL %s: item %0d actual %h expected %h", tag_mem[rcv], rcv,
                   {out_invalid, out_underflow, out_overflow, out_result}, exp_mem[rcv]);
        end
        checks++;
        if (cyc - issue_cyc[rcv] != 3) begin
          errors++;
          $display("FAIL R2 R12 latency: item %0d actual %0d expected 3", rcv,
                   cyc - issue_cyc[rcv]);
        end
        rcv++;
      end
    end
  end

  task automatic check_no_valid(input string tag);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_valid actual %b expected 0", tag, out_valid);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = 19'h0;
    in_b     = 19'h0;
    repeat (3) @(negedge clk);
    check_no_valid("R3 reset state");
    rst_n = 1'b1;

    // directed corners, back to back (R12)
    send(mk(0,127,0),   mk(0,127,0),   "R1 unity");
    send(mk(0,127,512), mk(0,127,512), "R1 1.5 squared");
    send(mk(1,130,300), mk(0,120,77),  "R11 mixed sign");
    send(mk(0,127,1),   mk(0,127,512), "R5 tie odd up");
    send(mk(0,127,3),   mk(0,127,512), "R5 tie even stays");
    send(mk(0,127,424), mk(0,127,424), "R5 carry renormalize");
    send(mk(0,190,424), mk(0,191,424), "R6 carry overflow");
    send(mk(1,200,0),   mk(0,200,0),   "R6 overflow");
    send(mk(0,254,1023),mk(0,127,0),   "R6 max finite");
    send(mk(1,1,0),     mk(0,1,0),     "R7 underflow");
    send(mk(0,63,424),  mk(0,64,424),  "R7 carry rescue");
    send(mk(0,1,0),     mk(0,127,0),   "R7 min normal");
    send(mk(1,0,5),     mk(0,130,7),   "R4 subnormal input");
    send(mk(0,0,0),     mk(0,255,0),   "R8 zero times inf");
    send(mk(1,255,0),   mk(0,0,9),     "R8 R4 inf times subnormal");
    send(mk(0,255,1),   mk(0,0,0),     "R9 nan times zero");
    send(mk(1,100,3),   mk(0,255,700), "R9 nan operand");
    send(mk(1,255,0),   mk(1,255,0),   "R10 inf times inf");
    send(mk(0,255,0),   mk(1,3,5),     "R10 inf times finite");
    send(mk(1,0,0),     mk(1,200,0),   "R10 zero times finite");
    idle(6);

    // reset with results in flight (R3)
    send(mk(0,127,0), mk(0,127,0), "R3 dropped");
    send(mk(0,128,0), mk(0,127,0), "R3 dropped");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    check_no_valid("R3 async clear");
    rcv = iss;
    repeat (3) @(negedge clk);
    check_no_valid("R3 held in reset");
    rst_n = 1'b1;
    idle(4);
    check_no_valid("R3 no stale output");

    // constrained random with gaps
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 4) == 0) idle(1);
      else send(rand_op(), rand_op(), "R1 R11 random");
    end
    idle(8);

    checks++;
    if (rcv != iss) begin
      errors++;
      $display("FAIL R12: results actual %0d expected %0d", rcv, iss);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule